// File: doc/BRIEF.md
# Cache ECC Error Reporting Unit

This unit sits beside a shared cache's error-correction logic and turns its error events into software-visible state. The cache reports each event as a single-cycle pulse with a 2-bit class and the 64-bit address that failed. There are four classes: a correctable and an uncorrectable class for the directory storage, and the same pair for the data storage. Each class has its own latched failing address, its own saturating event counter and its own interrupt line.

An interrupt is acknowledged by reading that class's count register. No write is needed. A handler therefore reads the two address words first and the count last. The unit also has three more registers. A configuration register reports the cache geometry. A readback register shows the largest enabled way. An error-injection register sends a one-cycle corrupt request, with a bit index and a target array, to the cache.

All access uses a 32-bit register bus with single-cycle read and write strobes. Read data is registered.

Top module: `ecc_err_report`

## Requirements
- R1: After reset, all interrupt lines are low. Every address word and every count register reads 0. The injection register reads 0 and the inject pulse is low.
- R2: An event of class c loads its 64-bit address into class c's address registers. The low word is at base+0x0 and the high word at base+0x4. A later event of the same class overwrites both words. Address registers of other classes do not change.
- R3: Each event of class c adds one to class c's count register at base+0x8. The count has CNT_W bits and is zero-extended to 32 bits. Once it holds all ones it stays there.
- R4: The class code on ev_class_i is 0 for directory-correctable, 1 for data-correctable, 2 for data-uncorrectable and 3 for directory-uncorrectable. The register bases are 0x100, 0x140, 0x160 and 0x120 respectively. Interrupt irq_o[c] goes high on the clock edge that takes an event of class c.
- R5: A bus read of class c's count register clears irq_o[c] on that edge. Reading the address words leaves the interrupt unchanged.
- R6: An event and a count read can reach the same class in the same cycle. In that case the interrupt stays high and the count still increments. The read returns the count from before the increment.
- R7: Offset 0x00 reads as follows: bank count in bits 7:0, way count in bits 15:8, log2 of sets per bank in bits 23:16 and log2 of line bytes in bits 31:24. The line field is 6 for 64-byte lines.
- R8: Offset 0x08 returns largest_way_i in bits 7:0, with the upper bits zero.
- R9: A write to offset 0x40 is accepted when the value is below 0xFF, or is from 0x10000 up to but not including 0x100FF. An accepted write gives inj_pulse_o high for exactly the next cycle. inj_bit_o carries bits 7:0 and inj_dir_o carries bit 16 (1 = directory, 0 = data). Offset 0x40 then reads {bit 16, bits 7:0}.
- R10: Writes to 0x40 outside the accepted ranges give no pulse and leave the readback value of 0x40 unchanged.
- R11: Unmapped offsets read as 0. Writes to any offset other than 0x40 change nothing.
- R12: bus_rdata_o takes the addressed value on the edge where bus_rd_i is sampled high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid_i | input | 1 | Error event strobe from the cache |
| ev_class_i | input | 2 | Class of the event (see R4) |
| ev_addr_i | input | 64 | Failing address of the event |
| largest_way_i | input | 8 | Index of the largest enabled way |
| bus_addr_i | input | 12 | Register byte offset |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 4 | One interrupt per class, indexed by class code |
| inj_pulse_o | output | 1 | One-cycle error-injection request |
| inj_dir_o | output | 1 | Injection target: 1 directory, 0 data |
| inj_bit_o | output | 8 | Bit index to corrupt |

## Verification
The assertions assume at most one event per cycle and a class code that is always valid. They also assume bus_rd_i and bus_wr_i are never high together, so a count read is never mixed with a write in one cycle. The stimulus drives every input at the falling edge and holds it for one full cycle. Reads and writes are issued in separate steps. The only overlap it creates is the intended one: an event and a count read of the same class in one cycle. A behavioural model tracks addresses, counts, interrupts and injection state, and it is compared with the outputs on every cycle.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

  localparam int NUM_CLASSES = 4;

  typedef enum logic [1:0] {
    CLS_DIR_FIX   = 2'd0,
    CLS_DATA_FIX  = 2'd1,
    CLS_DATA_FAIL = 2'd2,
    CLS_DIR_FAIL  = 2'd3
  } ecc_class_e;

  typedef enum logic [1:0] {
    WORD_ADDR_LO = 2'd0,
    WORD_ADDR_HI = 2'd1,
    WORD_COUNT   = 2'd2,
    WORD_NONE    = 2'd3
  } slot_word_e;

  localparam logic [11:0] OFS_CONFIG = 12'h000;
  localparam logic [11:0] OFS_WAYS   = 12'h008;
  localparam logic [11:0] OFS_INJECT = 12'h040;

  // Register groups inside the 0x100 page are 32 bytes apart; group order
  // differs from class order, so translate here.
  function automatic logic [1:0] group_to_class(input logic [1:0] grp);
    case (grp)
      2'd0:    return CLS_DIR_FIX;
      2'd1:    return CLS_DIR_FAIL;
      2'd2:    return CLS_DATA_FIX;
      default: return CLS_DATA_FAIL;
    endcase
  endfunction

endpackage

// File: rtl/ecc_err_decode.sv
module ecc_err_decode
  import ecc_err_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0]          addr_i,
  output logic                   cfg_hit_o,
  output logic                   way_hit_o,
  output logic                   inj_hit_o,
  output logic [NUM_CLASSES-1:0] cls_hit_o,
  output slot_word_e             word_o
);

  localparam int PAGE_W = AW - 8;

  logic       in_page;
  logic [1:0] grp_cls;

  always_comb begin
    cfg_hit_o = (addr_i == AW'(OFS_CONFIG));
    way_hit_o = (addr_i == AW'(OFS_WAYS));
    inj_hit_o = (addr_i == AW'(OFS_INJECT));
    in_page   = (addr_i[AW-1:8] == PAGE_W'(1)) && (addr_i[1:0] == 2'b00);
    case (addr_i[4:2])
      3'd0:    word_o = WORD_ADDR_LO;
      3'd1:    word_o = WORD_ADDR_HI;
      3'd2:    word_o = WORD_COUNT;
      default: word_o = WORD_NONE;
    endcase
    grp_cls   = group_to_class(addr_i[6:5]);
    cls_hit_o = '0;
    if (in_page && !addr_i[7] && word_o != WORD_NONE) begin
      cls_hit_o[grp_cls] = 1'b1;
    end
  end

endmodule

// File: rtl/ecc_err_slot.sv
module ecc_err_slot #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              irq_q, irq_d;
  logic              addr_en, cnt_en;

  always_comb begin
    addr_en = ev_i;
    addr_d  = ev_addr_i;
    cnt_en  = ev_i && (cnt_q != CNT_MAX);
    cnt_d   = cnt_q + 1'b1;
    irq_d   = ev_i | (irq_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;

  AST_EVENT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i |=> irq_o); // R4
  AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ev_i) |=> !irq_o); // R5
  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_i |=> $stable(cnt_o)); // R3
  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_i |=> $stable(addr_o)); // R2
  AST_COLLIDE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && clr_i && cnt_o != CNT_MAX) |=> (cnt_o != $past(cnt_o))); // R6

endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        pulse_o,
  output logic        dir_o,
  output logic [7:0]  bit_o,
  output logic [31:0] value_o
);

  logic       pulse_q, pulse_d;
  logic       dir_q;
  logic [7:0] bit_q;
  logic       in_low, in_high, accept;

  always_comb begin
    in_low  = (wdata_i < 32'h0000_00FF);
    in_high = (wdata_i >= 32'h0001_0000) && (wdata_i < 32'h0001_00FF);
    accept  = wr_i && (in_low || in_high);
    pulse_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      dir_q   <= 1'b0;
      bit_q   <= '0;
    end else begin
      pulse_q <= pulse_d;
      if (accept) begin
        dir_q <= wdata_i[16];
        bit_q <= wdata_i[7:0];
      end
    end
  end

  assign pulse_o = pulse_q;
  assign dir_o   = dir_q;
  assign bit_o   = bit_q;
  assign value_o = {15'd0, dir_q, 8'd0, bit_q};

  AST_INJ_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(bit_o) && $stable(dir_o))); // R10

endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
  import ecc_err_pkg::*;
#(
  parameter int BUS_AW    = 12,
  parameter int EV_AW     = 64,
  parameter int CNT_W     = 32,
  parameter int NUM_BANKS = 4,
  parameter int NUM_WAYS  = 16,
  parameter int LOG2_SETS = 10,
  parameter int LOG2_LINE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid_i,
  input  logic [1:0]        ev_class_i,
  input  logic [EV_AW-1:0]  ev_addr_i,
  input  logic [7:0]        largest_way_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [3:0]        irq_o,
  output logic              inj_pulse_o,
  output logic              inj_dir_o,
  output logic [7:0]        inj_bit_o
);

  localparam logic [31:0] CFG_WORD = {8'(LOG2_LINE), 8'(LOG2_SETS),
                                      8'(NUM_WAYS), 8'(NUM_BANKS)};

  logic                   cfg_hit, way_hit, inj_hit;
  logic [NUM_CLASSES-1:0] cls_hit;
  slot_word_e             word_sel;
  logic [31:0]            inj_value;
  logic [EV_AW-1:0]       slot_addr [NUM_CLASSES];
  logic [CNT_W-1:0]       slot_cnt  [NUM_CLASSES];
  logic [31:0]            rdata_q, rdata_d;
  logic                   rdata_en;
  logic                   any_hit;

  ecc_err_decode #(.AW(BUS_AW)) u_decode (
    .addr_i    (bus_addr_i),
    .cfg_hit_o (cfg_hit),
    .way_hit_o (way_hit),
    .inj_hit_o (inj_hit),
    .cls_hit_o (cls_hit),
    .word_o    (word_sel)
  );

  ecc_inject_ctrl u_inject (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr_i && inj_hit),
    .wdata_i (bus_wdata_i),
    .pulse_o (inj_pulse_o),
    .dir_o   (inj_dir_o),
    .bit_o   (inj_bit_o),
    .value_o (inj_value)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_slot
    logic ev_c, clr_c;
    assign ev_c  = ev_valid_i && (ev_class_i == 2'(c));
    assign clr_c = bus_rd_i && cls_hit[c] && (word_sel == WORD_COUNT);
    ecc_err_slot #(.ADDR_W(EV_AW), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_i      (ev_c),
      .ev_addr_i (ev_addr_i),
      .clr_i     (clr_c),
      .addr_o    (slot_addr[c]),
      .cnt_o     (slot_cnt[c]),
      .irq_o     (irq_o[c])
    );
  end

  always_comb begin
    rdata_d  = '0;
    rdata_en = bus_rd_i;
    any_hit  = cfg_hit | way_hit | inj_hit | (|cls_hit);
    if (cfg_hit) rdata_d = CFG_WORD;
    if (way_hit) rdata_d = {24'd0, largest_way_i};
    if (inj_hit) rdata_d = inj_value;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (cls_hit[c]) begin
        case (word_sel)
          WORD_ADDR_LO: rdata_d = slot_addr[c][31:0];
          WORD_ADDR_HI: rdata_d = slot_addr[c][63:32];
          WORD_COUNT:   rdata_d[CNT_W-1:0] = slot_cnt[c];
          default:      rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;

  AST_INJ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pulse_o |-> $past(bus_wr_i && inj_hit)); // R9
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !any_hit) |=> (bus_rdata_o == 32'd0)); // R11
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o)); // R12

endmodule

// File: tb/ecc_err_report_tb_top.sv
`timescale 1ns/1ps
module ecc_err_report_tb_top;

  localparam int TB_CNT_W = 4;
  localparam int CNT_MAX  = (1 << TB_CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid_i = 1'b0;
  logic [1:0]  ev_class_i = '0;
  logic [63:0] ev_addr_i = '0;
  logic [7:0]  largest_way_i = 8'h0B;
  logic [11:0] bus_addr_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [3:0]  irq_o;
  logic        inj_pulse_o, inj_dir_o;
  logic [7:0]  inj_bit_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  ecc_err_report #(.CNT_W(TB_CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid_i(ev_valid_i), .ev_class_i(ev_class_i),
    .ev_addr_i(ev_addr_i), .largest_way_i(largest_way_i), .bus_addr_i(bus_addr_i),
    .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .inj_pulse_o(inj_pulse_o),
    .inj_dir_o(inj_dir_o), .inj_bit_o(inj_bit_o)
  );

  // Behavioural reference model
  logic [63:0] m_addr [4];
  int          m_cnt  [4];
  logic [3:0]  m_irq;
  logic [31:0] m_rdata;
  logic        m_pulse, m_dir;
  logic [7:0]  m_bit;
  string       cur_tag = "R12";
  string       rd_tag  = "R12";

  function automatic int base_of(input int c);
    case (c)
      0: return 'h100;
      1: return 'h140;
      2: return 'h160;
      default: return 'h120;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] v = '0;
    if (a == 'h000) v = 32'h060A_1004;
    else if (a == 'h008) v = {24'd0, largest_way_i};
    else if (a == 'h040) v = {15'd0, m_dir, 8'd0, m_bit};
    for (int c = 0; c < 4; c++) begin
      if (a == base_of(c))     v = m_addr[c][31:0];
      if (a == base_of(c) + 4) v = m_addr[c][63:32];
      if (a == base_of(c) + 8) v = 32'(m_cnt[c]);
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin m_addr[c] = '0; m_cnt[c] = 0; end
      m_irq = '0; m_rdata = '0; m_pulse = 0; m_dir = 0; m_bit = '0;
    end else begin
      m_pulse = 0;
      if (bus_rd_i) begin
        m_rdata = model_read(int'(bus_addr_i));
        rd_tag  = cur_tag;
        for (int c = 0; c < 4; c++)
          if (int'(bus_addr_i) == base_of(c) + 8) m_irq[c] = 1'b0;
      end
      if (bus_wr_i && bus_addr_i == 12'h040 &&
          (bus_wdata_i < 32'hFF || (bus_wdata_i >= 32'h10000 && bus_wdata_i < 32'h100FF))) begin
        m_pulse = 1; m_dir = bus_wdata_i[16]; m_bit = bus_wdata_i[7:0];
      end
      if (ev_valid_i) begin
        m_addr[ev_class_i] = ev_addr_i;
        if (m_cnt[ev_class_i] < CNT_MAX) m_cnt[ev_class_i]++;
        m_irq[ev_class_i] = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    chk("R4 R5 R6 irq", 64'(irq_o), 64'(m_irq));
    chk("R9 R10 pulse", 64'(inj_pulse_o), 64'(m_pulse));
    if (m_pulse) begin
      chk("R9 bit", 64'(inj_bit_o), 64'(m_bit));
      chk("R9 dir", 64'(inj_dir_o), 64'(m_dir));
    end
    chk(rd_tag, 64'(bus_rdata_o), 64'(m_rdata));
  end

  task automatic step(input logic ev, input logic [1:0] cls, input logic [63:0] ea,
                      input logic rd, input logic wr, input logic [11:0] a,
                      input logic [31:0] wd, input string tag);
    @(negedge clk);
    ev_valid_i = ev; ev_class_i = cls; ev_addr_i = ea;
    bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd; cur_tag = tag;
    @(posedge clk);
    #1;
    ev_valid_i = 0; bus_rd_i = 0; bus_wr_i = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(0, 0, 0, 1, 0, a, 0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(0, 0, 0, 0, 1, a, d, tag);
  endtask
  task automatic ev(input logic [1:0] c, input logic [63:0] a);
    step(1, c, a, 0, 0, 0, 0, "R4");
  endtask
  task automatic idle;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every class register and the injection register
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 3; w++) rd(12'(base_of(c) + 4 * w), "R1");
    rd(12'h040, "R1");
    // R7, R8
    rd(12'h000, "R7");
    @(negedge clk);
    chk("R7 cfg direct", 64'(bus_rdata_o), 64'h060A_1004);
    rd(12'h008, "R8");
    largest_way_i = 8'h2C;
    rd(12'h008, "R8");
    // R2, R4, R5: one event on class 0, address reads keep irq
    ev(2'd0, 64'hDEAD_BEEF_0000_1240);
    idle;
    rd(12'h100, "R2");
    rd(12'h104, "R2");
    @(negedge clk);
    chk("R5 irq kept", 64'(irq_o[0]), 64'd1);
    rd(12'h108, "R5");
    @(negedge clk);
    chk("R5 irq cleared", 64'(irq_o[0]), 64'd0);
    // R4: class code to register base mapping
    ev(2'd1, 64'h1111_0000_2222_0040);
    ev(2'd2, 64'h3333_0000_4444_0080);
    ev(2'd3, 64'h5555_0000_6666_00C0);
    for (int c = 1; c < 4; c++)
      for (int w = 0; w < 3; w++) rd(12'(base_of(c) + 4 * w), "R4");
    // R2: newest address overwrites
    ev(2'd1, 64'h0000_0001_0000_0001);
    ev(2'd1, 64'hFFFF_FFFE_8000_0000);
    rd(12'h140, "R2"); rd(12'h144, "R2"); rd(12'h148, "R3");
    rd(12'h100, "R2");
    // R6: event and count read of the same class together
    step(1, 2'd3, 64'h7777_0000_0000_0100, 1, 0, 12'h128, 0, "R6");
    @(negedge clk);
    chk("R6 old count", 64'(bus_rdata_o), 64'd1);
    chk("R6 irq stays", 64'(irq_o[3]), 64'd1);
    rd(12'h128, "R6");
    // R3: saturation
    for (int i = 0; i < CNT_MAX + 5; i++) ev(2'd2, 64'(i));
    rd(12'h168, "R3");
    @(negedge clk);
    chk("R3 saturated", 64'(bus_rdata_o), 64'(CNT_MAX));
    // R9 / R10: injection ranges and boundaries
    wr(12'h040, 32'h0000_0005, "R9"); idle;
    wr(12'h040, 32'h0001_0012, "R9"); idle;
    rd(12'h040, "R9");
    wr(12'h040, 32'h0000_00FE, "R9");
    wr(12'h040, 32'h0001_00FE, "R9"); idle;
    wr(12'h040, 32'h0000_00FF, "R10"); idle;
    wr(12'h040, 32'h0001_00FF, "R10"); idle;
    wr(12'h040, 32'h0002_0000, "R10"); idle;
    rd(12'h040, "R10");
    @(negedge clk);
    chk("R10 readback", 64'(bus_rdata_o), 64'h0001_00FE);
    // R11: unmapped reads and ignored writes
    rd(12'h10C, "R11"); rd(12'h180, "R11"); rd(12'h004, "R11"); rd(12'h0FC, "R11");
    wr(12'h100, 32'hCAFE_F00D, "R11");
    wr(12'h108, 32'h0000_0007, "R11");
    rd(12'h100, "R11"); rd(12'h108, "R11");
    // R12: data holds between reads
    repeat (4) idle;
    repeat (2) idle;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule